// File: doc/BRIEF.md
# Serial Register Port (SPI Mode 3 Slave)

This block lets an external SPI master read and write a bank of 16-bit user registers. It is a slave only. It works in mode 3: the serial clock idles high, the block samples inbound data on rising edges and changes outbound data on falling edges. Chip select, serial clock and data in pass through two-flop synchronizers into the system clock. The system clock must run at least eight times faster than the serial clock, which may run at up to 2.5 MHz. Every transaction is a 16-bit word, most significant bit first, and data moves in both directions at once.

Each inbound word holds three fields. Bit 15 is the direction flag. Bits 14:8 are a 7-bit register address. Bits 7:0 are a data byte. A write frame produces a one-cycle strobe to the register bank, carrying the address and the byte. The register bank uses address bit 0 to pick the upper or lower half of a 16-bit register. A read frame latches its address. The register bank returns that register combinationally. The block then shifts the 16-bit result out during the following frame, so the reply to any read arrives one frame late.

The block also drives one general-purpose line. A 3-bit indicator configuration selects what appears on it: a plain general-purpose level, the live data-ready signal, or a latched data-ready flag that clears when a frame ends. The polarity is selectable.

Top module: `spi_regport`

## Requirements
- R1: While chip select is low, each rising edge of the serial clock captures one data-in bit, most significant bit first. 16 captured bits form one frame.
- R2: A complete frame with bit 15 = 1 causes one write strobe. The strobe carries address = bits 14:8 and data = bits 7:0 and appears three system cycles after the system clock edge that follows the 16th rising serial-clock edge. In the register bank, an odd address writes the upper byte and an even address writes the lower byte.
- R3: A complete frame with bit 15 = 0 latches bits 14:8 as the read address. During the next frame, the 16-bit register value at that address is shifted out on data out, MSB first, and data out changes only after falling serial-clock edges.
- R4: A read frame ignores its data byte. It causes no write strobe, and its reply does not depend on that byte.
- R5: A write frame leaves the pending read address unchanged. The frame after a write returns the current contents of the register named by the last read request.
- R6: Until a read frame has completed after reset, every frame shifts out 16 zero bits.
- R7: If chip select rises before the 16th rising edge, the frame is aborted. An aborted frame causes no write and does not change the read address, and the next frame starts aligned at bit 15.
- R8: After reset, the write strobe is low, data out is 0 and the read address is 0.
- R9: With chip select held low, frames follow each other every 16 rising edges. The bit counter wraps, and each frame is decoded and answered as if it were separate.
- R10: With indicator configuration bit 2 = 0, the general-purpose line follows the general-purpose level input.
- R11: With configuration bit 2 = 1 and bit 0 = 0, the line follows the data-ready input. Configuration bit 1 = 1 makes the line active high; bit 1 = 0 makes it active low.
- R12: With configuration bits 2 and 0 both = 1, a data-ready pulse sets a flag. The flag holds until a frame completes and is then cleared one cycle after that frame's decode. The polarity follows bit 1 as in R11.
- R13: The write strobe never stays high for two consecutive system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Active-low chip select from the master |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| wr_en_o | output | 1 | One-cycle write strobe to the register bank |
| wr_addr_o | output | 7 | Write address |
| wr_data_o | output | 8 | Write data byte |
| rd_addr_o | output | 7 | Latched read address to the register bank |
| rd_data_i | input | 16 | Register value at rd_addr_o (combinational) |
| ind_cfg_i | input | 3 | Indicator configuration: [2] enable, [1] active-high, [0] latch |
| drdy_i | input | 1 | Data-ready pulse from the datapath |
| gp_out_i | input | 1 | General-purpose level for the line |
| io_line_o | output | 1 | Configurable general-purpose / data-ready line |

## Verification
The bench tests four things.

- **First frame after reset.** It must shift out zeros even though the register bank holds nonzero data at address 0. A design that ignored this would reply with that data.
- **Frame after a write.** It must still answer the earlier read request. A design that reused the write address as the read address would return the wrong register.
- **Aborted frame.** The bench cuts a write frame off after nine bits. A design that kept its bit counter would misalign the next frame, and one that committed partial words would produce a spurious strobe.
- **Chip select held low.** Frames are also run back to back this way, which exposes a counter that fails to wrap.

Each of the three indicator modes is checked in both polarities, and the latched flag must clear at the end of a frame.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int FRAME_W   = 16;
    localparam int ADDR_W    = 7;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = $clog2(FRAME_W);
    localparam int SYNC_DEPTH = 2;

    typedef enum logic {
        CMD_READ  = 1'b0,
        CMD_WRITE = 1'b1
    } cmd_e;

    typedef struct packed {
        cmd_e              cmd;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic en;
        logic act_high;
        logic latch;
    } ind_cfg_t;

    function automatic frame_t to_frame(input logic [FRAME_W-1:0] w);
        return frame_t'(w);
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int          N      = 3,
    parameter int          STAGES = spi_regport_pkg::SYNC_DEPTH,
    parameter logic [N-1:0] INIT  = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [STAGES-1:0][N-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q[0] <= INIT;
                else       chain_q[0] <= async_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= {STAGES{INIT}};
                else       chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
    import spi_regport_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cs_act_i,
    input  logic             rise_i,
    input  logic             mosi_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o,
    output frame_t           frame_o
);
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] sh_q;
    logic [FRAME_W-1:0] word_next;

    assign word_next = {sh_q[FRAME_W-2:0], mosi_i};
    assign done_o    = cs_act_i && rise_i && (cnt_q == CNT_W'(FRAME_W-1));
    assign frame_o   = to_frame(word_next);
    assign cnt_o     = cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (!cs_act_i) begin
            cnt_q <= '0;
        end else if (rise_i) begin
            sh_q  <= word_next;
            cnt_q <= (cnt_q == CNT_W'(FRAME_W-1)) ? '0 : cnt_q + 1'b1;
        end
    end

    // R7: deselect realigns the frame
    p_abort_clear_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !cs_act_i |=> (cnt_q == '0));
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
    import spi_regport_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              done_i,
    input  frame_t            frame_i,
    output wr_req_t           wr_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              rd_valid_o
);
    wr_req_t           wr_q;
    logic [ADDR_W-1:0] rd_addr_q;
    logic              rd_valid_q;
    logic              is_wr, is_rd;

    assign is_wr = done_i && (frame_i.cmd == CMD_WRITE);
    assign is_rd = done_i && (frame_i.cmd == CMD_READ);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            wr_q       <= '0;
            rd_addr_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            wr_q.valid <= is_wr;
            if (is_wr) begin
                wr_q.addr <= frame_i.addr;
                wr_q.data <= frame_i.data;
            end
            if (is_rd) begin
                rd_addr_q  <= frame_i.addr;
                rd_valid_q <= 1'b1;
            end
        end
    end

    assign wr_o       = wr_q;
    assign rd_addr_o  = rd_addr_q;
    assign rd_valid_o = rd_valid_q;

    // R13: strobe lasts a single cycle
    p_wr_single_r13: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_q.valid |=> !wr_q.valid);
    // R5: only a completed read moves the read address
    p_rd_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !(done_i && frame_i.cmd == CMD_READ) |=> $stable(rd_addr_q));
endmodule

// File: rtl/spi_tx_pipe.sv
module spi_tx_pipe
    import spi_regport_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               cs_act_i,
    input  logic               fall_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic               rd_valid_i,
    input  logic [FRAME_W-1:0] rd_data_i,
    output logic               miso_o
);
    logic [FRAME_W-1:0] sh_q;
    logic               first_bit;

    assign first_bit = (cnt_i == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh_q <= '0;
        end else if (cs_act_i && fall_i) begin
            if (first_bit) sh_q <= rd_valid_i ? rd_data_i : '0;
            else           sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign miso_o = sh_q[FRAME_W-1];

    // R3: later falling edges advance the reply by one bit
    p_shift_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (cs_act_i && fall_i && !first_bit) |=> (miso_o == $past(sh_q[FRAME_W-2])));
    // R6: no completed read yet means a zero reply
    p_first_zero_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (cs_act_i && fall_i && first_bit && !rd_valid_i) |=> (sh_q == '0));
endmodule

// File: rtl/spi_ind_mux.sv
module spi_ind_mux
    import spi_regport_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  ind_cfg_t cfg_i,
    input  logic     drdy_i,
    input  logic     gp_i,
    input  logic     frame_end_i,
    output logic     line_o
);
    logic hold_q;
    logic ind;

    always_ff @(posedge clk_i) begin
        if (rst_i)            hold_q <= 1'b0;
        else if (drdy_i)      hold_q <= 1'b1;
        else if (frame_end_i) hold_q <= 1'b0;
    end

    always_comb begin
        ind = cfg_i.latch ? hold_q : drdy_i;
        if (cfg_i.en) line_o = cfg_i.act_high ? ind : ~ind;
        else          line_o = gp_i;
    end

    // R12: a pulse always sets the flag
    p_latch_set_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        drdy_i |=> hold_q);
endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               spi_cs_n,
    input  logic               spi_sclk,
    input  logic               spi_mosi,
    output logic               spi_miso,
    output logic               wr_en_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic [BYTE_W-1:0]  wr_data_o,
    output logic [ADDR_W-1:0]  rd_addr_o,
    input  logic [FRAME_W-1:0] rd_data_i,
    input  logic [2:0]         ind_cfg_i,
    input  logic               drdy_i,
    input  logic               gp_out_i,
    output logic               io_line_o
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] SYNC_INIT = 3'b110;

    logic [NSIG-1:0]  pins_s;
    logic             cs_act, sclk_s, mosi_s, sclk_d_q;
    logic             rise, fall, done;
    logic [CNT_W-1:0] cnt;
    frame_t           frame;
    wr_req_t          wr;
    logic             rd_valid;

    spi_sync #(.N(NSIG), .STAGES(SYNC_DEPTH), .INIT(SYNC_INIT)) u_sync (
        .clk_i(clk), .rst_i(rst),
        .async_i({spi_cs_n, spi_sclk, spi_mosi}),
        .sync_o(pins_s)
    );

    assign cs_act = ~pins_s[2];
    assign sclk_s = pins_s[1];
    assign mosi_s = pins_s[0];

    always_ff @(posedge clk) begin
        if (rst) sclk_d_q <= 1'b1;
        else     sclk_d_q <= sclk_s;
    end

    assign rise = sclk_s & ~sclk_d_q;
    assign fall = ~sclk_s & sclk_d_q;

    spi_frame_rx u_rx (
        .clk_i(clk), .rst_i(rst), .cs_act_i(cs_act), .rise_i(rise),
        .mosi_i(mosi_s), .cnt_o(cnt), .done_o(done), .frame_o(frame)
    );

    spi_cmd_decode u_dec (
        .clk_i(clk), .rst_i(rst), .done_i(done), .frame_i(frame),
        .wr_o(wr), .rd_addr_o(rd_addr_o), .rd_valid_o(rd_valid)
    );

    spi_tx_pipe u_tx (
        .clk_i(clk), .rst_i(rst), .cs_act_i(cs_act), .fall_i(fall),
        .cnt_i(cnt), .rd_valid_i(rd_valid), .rd_data_i(rd_data_i),
        .miso_o(spi_miso)
    );

    spi_ind_mux u_ind (
        .clk_i(clk), .rst_i(rst), .cfg_i(ind_cfg_t'(ind_cfg_i)),
        .drdy_i(drdy_i), .gp_i(gp_out_i), .frame_end_i(done),
        .line_o(io_line_o)
    );

    assign wr_en_o   = wr.valid;
    assign wr_addr_o = wr.addr;
    assign wr_data_o = wr.data;
endmodule

// File: tb/spi_regport_bench.sv
module spi_regport_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, cs_n, sclk, mosi, miso;
    logic        wr_en;
    logic [6:0]  wr_addr, rd_addr;
    logic [7:0]  wr_data;
    logic [15:0] rd_data;
    logic [2:0]  cfg;
    logic        drdy, gp, line;

    int tests = 0;
    int fails = 0;

    spi_regport u_spi_regport (
        .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data), .ind_cfg_i(cfg), .drdy_i(drdy),
        .gp_out_i(gp), .io_line_o(line)
    );

    // register bank environment: odd address = upper byte
    logic [15:0] bank [64];
    assign rd_data = bank[rd_addr[6:1]];
    always @(posedge clk) begin
        if (wr_en) begin
            if (wr_addr[0]) bank[wr_addr[6:1]][15:8] <= wr_data;
            else            bank[wr_addr[6:1]][7:0]  <= wr_data;
        end
    end

    function automatic logic [15:0] init_val(input int i);
        return 16'(16'hA5C3 ^ (i * 16'h0111));
    endfunction

    // behavioural reference state
    logic [6:0]  m_rd_addr;
    bit          m_valid;
    int          cd;
    bit          fire_any;
    logic [15:0] pend_w;
    bit          m_hold;

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            cd = 0; fire_any = 0; m_hold = 0;
        end else begin
            fire_any = 0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) fire_any = 1;
            end
            if (drdy) m_hold = 1;
            else if (fire_any) m_hold = 0;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            bit exp_wr;
            logic ind, exp_line;
            string rq;
            exp_wr = fire_any && pend_w[15];
            check(wr_en === exp_wr, exp_wr ? "R2" : "R13", {15'd0, wr_en}, {15'd0, exp_wr});
            if (exp_wr) begin
                check(wr_addr === pend_w[14:8], "R2", {9'd0, wr_addr}, {9'd0, pend_w[14:8]});
                check(wr_data === pend_w[7:0], "R2", {8'd0, wr_data}, {8'd0, pend_w[7:0]});
            end
            ind = cfg[0] ? m_hold : drdy;
            exp_line = cfg[2] ? (cfg[1] ? ind : ~ind) : gp;
            rq = !cfg[2] ? "R10" : (cfg[0] ? "R12" : "R11");
            check(line === exp_line, rq, {15'd0, line}, {15'd0, exp_line});
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    function automatic logic [15:0] exp_reply();
        return m_valid ? bank[m_rd_addr[6:1]] : 16'h0000;
    endfunction

    task automatic shift_bits(input logic [15:0] w, input int nbits, output logic [15:0] got);
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = w[15-i];
            tick(4);
            got = {got[14:0], miso};
            sclk = 1'b1;
            if (i == 15) begin
                cd = 3;
                pend_w = w;
            end
            tick(4);
        end
        if (nbits == 16 && !w[15]) begin
            m_rd_addr = w[14:8];
            m_valid = 1;
        end
    endtask

    task automatic frame(input logic [15:0] w, input string req);
        logic [15:0] exp, got;
        exp = exp_reply();
        cs_n = 1'b0;
        tick(4);
        shift_bits(w, 16, got);
        tick(4);
        cs_n = 1'b1;
        tick(6);
        check(got === exp, req, got, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] got, exp;
        for (int i = 0; i < 64; i++) bank[i] = init_val(i);
        rst = 1'b1; cs_n = 1'b1; sclk = 1'b1; mosi = 1'b0;
        cfg = 3'b000; drdy = 1'b0; gp = 1'b0;
        m_rd_addr = '0; m_valid = 0; pend_w = '0;
        tick(5);
        // R8: reset state
        check(miso === 1'b0, "R8", {15'd0, miso}, 16'h0);
        check(wr_en === 1'b0, "R8", {15'd0, wr_en}, 16'h0);
        check(rd_addr === 7'd0, "R8", {9'd0, rd_addr}, 16'h0);
        rst = 1'b0;
        tick(3);

        // R6 + R4: first read after reset replies zero, data byte ignored
        frame({1'b0, 7'h10, 8'h5A}, "R6");
        check(rd_addr === 7'h10, "R1", {9'd0, rd_addr}, 16'h0010);
        // R3: reply to the read of 0x10
        frame({1'b0, 7'h22, 8'hFF}, "R3");
        check(rd_addr === 7'h22, "R3", {9'd0, rd_addr}, 16'h0022);
        // R2: upper byte write, reply still from pending read 0x22 (R5)
        frame({1'b1, 7'h23, 8'h3C}, "R5");
        check(rd_addr === 7'h22, "R5", {9'd0, rd_addr}, 16'h0022);
        exp = {8'h3C, init_val(17)[7:0]};
        frame({1'b1, 7'h22, 8'hC3}, "R5");
        check(bank[17] === {8'h3C, 8'hC3}, "R2", bank[17], {8'h3C, 8'hC3});
        exp = {8'h3C, 8'hC3};
        got = exp_reply();
        check(got === exp, "R2", got, exp);
        frame({1'b0, 7'h40, 8'h00}, "R5");

        // R7: abort a write after nine bits
        cs_n = 1'b0;
        tick(4);
        shift_bits({1'b1, 7'h40, 8'hFF}, 9, got);
        tick(4);
        cs_n = 1'b1;
        tick(6);
        check(rd_addr === 7'h40, "R7", {9'd0, rd_addr}, 16'h0040);
        frame({1'b0, 7'h41, 8'h00}, "R7");
        frame({1'b0, 7'h05, 8'h00}, "R7");
        got = bank[32];
        check(got === init_val(32), "R7", got, init_val(32));

        // R9: back-to-back frames under one chip select
        cs_n = 1'b0;
        tick(4);
        exp = exp_reply();
        shift_bits({1'b0, 7'h06, 8'h11}, 16, got);
        check(got === exp, "R9", got, exp);
        exp = exp_reply();
        shift_bits({1'b1, 7'h07, 8'h99}, 16, got);
        check(got === exp, "R9", got, exp);
        exp = exp_reply();
        shift_bits({1'b0, 7'h09, 8'h00}, 16, got);
        check(got === exp, "R9", got, exp);
        tick(4);
        cs_n = 1'b1;
        tick(6);
        check(bank[3][15:8] === 8'h99, "R9", {8'd0, bank[3][15:8]}, 16'h0099);

        // R10: plain general-purpose level
        cfg = 3'b000; gp = 1'b1; tick(2);
        check(line === 1'b1, "R10", {15'd0, line}, 16'h1);
        drdy = 1'b1; gp = 1'b0; tick(1); drdy = 1'b0; tick(1);
        check(line === 1'b0, "R10", {15'd0, line}, 16'h0);
        // R11: live data-ready, both polarities
        cfg = 3'b110; drdy = 1'b1; #1;
        check(line === 1'b1, "R11", {15'd0, line}, 16'h1);
        cfg = 3'b100; #1;
        check(line === 1'b0, "R11", {15'd0, line}, 16'h0);
        drdy = 1'b0; tick(2);
        check(line === 1'b1, "R11", {15'd0, line}, 16'h1);
        // R12: latched flag, cleared by a completed frame
        cfg = 3'b111; tick(1);
        drdy = 1'b1; tick(1); drdy = 1'b0; tick(3);
        check(line === 1'b1, "R12", {15'd0, line}, 16'h1);
        frame({1'b0, 7'h0A, 8'h00}, "R3");
        check(line === 1'b0, "R12", {15'd0, line}, 16'h0);
        cfg = 3'b101; drdy = 1'b1; tick(1); drdy = 1'b0; tick(2);
        check(line === 1'b0, "R12", {15'd0, line}, 16'h0);
        frame({1'b0, 7'h0B, 8'h00}, "R3");
        check(line === 1'b1, "R12", {15'd0, line}, 16'h1);

        tick(10);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule